// File: doc/BRIEF.md
# Disc Sector Write Sequencer

This block writes one disc sector from data supplied by a DMA channel. It holds a one-word staging register that DMA fills and a serial shift register that feeds the disc. The staging register is loaded with a data strobe. The block asks for each word through a request flag, and DMA drops that flag with a separate clear signal. This lets DMA fill the next word while the current one is still being shifted out. Bits leave most significant first, one for each bit clock tick. While the block is writing, the active-low write-inhibit output is held low.

A write begins with a start command, which requests the first word. The first sector pulse after that moves the staged word into the shift register, opens the write gate and requests the following word. At each later word boundary the next staged word is moved across and requested the same way. When the transfer of the final word is made, an end-of-sector latch is set and no further request is raised. At the end of the final word the write gate closes. The block then ignores everything until it has seen two sector pulses, and after the second it is ready for a new start.

Top module: `sector_write_seq`

## Requirements
- R1: While reset is held, and after it is released, srq, eos, underrun and ser_out are 0, wr_n is 1 and word_cnt is 0.
- R2: In the idle state, a start pulse raises srq on the following cycle to request the first word. wr_n stays 1.
- R3: A dma_strobe pulse loads dma_data into the staging register. A dma_clear pulse drops srq on the following cycle, unless a new request is raised in that same cycle.
- R4: After a start, the first sector_pulse moves the staged word into the shift register, drives wr_n to 0 and raises srq for the next word. wr_n never falls without a sector_pulse in the cycle before.
- R5: While writing, ser_out shows the current bit of the word, most significant bit first. Each bit_tick advances exactly one bit, and with no tick the output holds. While wr_n is 1, ser_out is 0.
- R6: On the last bit tick of a word (the WORD_W-th), word_cnt increases by one. If that word was not the last one, the next staged word is moved into the shift register and srq is raised.
- R7: When the final word (word WORDS-1, counted from 0) is moved into the shift register, eos goes to 1 and srq is not raised. Over one sector, exactly WORDS requests are made.
- R8: On the last bit tick of word WORDS-1, wr_n returns to 1 and word_cnt reads WORDS.
- R9: After writing ends, start is ignored until the second sector_pulse has arrived. That second pulse clears eos and returns the block to idle, where start is accepted again.
- R10: If a word boundary arrives and no dma_strobe has occurred since the previous transfer (or since start), underrun goes to 1. The old staged word is written again. underrun stays at 1 until the next accepted start.
- R11: While writing, sector_pulse and start have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sector write (accepted only when idle) |
| sector_pulse | input | 1 | One-cycle sector mark from the disc |
| bit_tick | input | 1 | One-cycle bit clock pulse |
| dma_strobe | input | 1 | Load dma_data into the staging register |
| dma_clear | input | 1 | Clear the request flag |
| dma_data | input | WORD_W | Word supplied by DMA |
| srq | output | 1 | Service request for the next word |
| wr_n | output | 1 | Write inhibit, active low (0 = writing) |
| ser_out | output | 1 | Serial write data |
| eos | output | 1 | End-of-sector latch |
| underrun | output | 1 | Sticky flag: a word boundary found no fresh word |
| word_cnt | output | $clog2(WORDS+1) | Number of words written in this sector |

## Verification
The hardest case to reach from the ports is an underrun in the middle of a sector. To get there, DMA has to leave a request unanswered while the serial stream keeps running, and the bench then has to show that the old word was written a second time. The bench gets there with a DMA responder that clears one chosen request without strobing any data. It then compares the whole serial stream it collected against a word list in which that slot repeats the previous word. The two-pulse exit is reached by sending start after the first post-sector pulse, when the request must stay low, and again after the second pulse, when it must rise.

// File: rtl/sector_write_seq.sv
module sector_write_seq #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  localparam int CW = $clog2(WORDS + 1),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sector_pulse,
  input  logic              bit_tick,
  input  logic              dma_strobe,
  input  logic              dma_clear,
  input  logic [WORD_W-1:0] dma_data,
  output logic              srq,
  output logic              wr_n,
  output logic              ser_out,
  output logic              eos,
  output logic              underrun,
  output logic [CW-1:0]     word_cnt
);

  typedef enum logic [1:0] {IDLE, ARMED, RUN, DONE} state_t;

  state_t            state;
  logic [WORD_W-1:0] stage, shreg;
  logic [BW-1:0]     bcnt;
  logic              full, seen_one;

  wire run        = (state == RUN);
  wire go         = (state == IDLE) && start;
  wire last_bit   = run && bit_tick && (bcnt == BW'(WORD_W - 1));
  wire end_sector = last_bit && (word_cnt == CW'(WORDS - 1));
  wire xfer       = ((state == ARMED) && sector_pulse) || (last_bit && !end_sector);
  wire final_xfer = last_bit && (word_cnt == CW'(WORDS - 2));

  assign wr_n    = !run;
  assign ser_out = run && shreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IDLE;
      stage    <= '0;
      shreg    <= '0;
      bcnt     <= '0;
      full     <= 1'b0;
      seen_one <= 1'b0;
      srq      <= 1'b0;
      eos      <= 1'b0;
      underrun <= 1'b0;
      word_cnt <= '0;
    end else begin
      if (dma_strobe) stage <= dma_data;
      full <= dma_strobe || (full && !xfer && !go);

      if (go || (xfer && !final_xfer)) srq <= 1'b1;
      else if (dma_clear)              srq <= 1'b0;

      if (xfer) begin
        shreg <= stage;
        bcnt  <= '0;
        if (!full) underrun <= 1'b1;
      end else if (run && bit_tick) begin
        shreg <= shreg << 1;
        bcnt  <= bcnt + 1'b1;
      end

      if (final_xfer) eos <= 1'b1;
      if (last_bit)   word_cnt <= word_cnt + 1'b1;

      case (state)
        IDLE: if (start) begin
          state    <= ARMED;
          word_cnt <= '0;
          underrun <= 1'b0;
          eos      <= 1'b0;
        end
        ARMED: if (sector_pulse) state <= RUN;
        RUN:   if (end_sector) begin
          state    <= DONE;
          seen_one <= 1'b0;
        end
        DONE: if (sector_pulse) begin
          if (seen_one) begin
            state <= IDLE;
            eos   <= 1'b0;
          end
          seen_one <= 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sector_write_seq_chk.sv
module sector_write_seq_chk #(
  parameter int WORDS = 64,
  localparam int CW = $clog2(WORDS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          sector_pulse,
  input logic          srq,
  input logic          wr_n,
  input logic          ser_out,
  input logic          eos,
  input logic          underrun,
  input logic [CW-1:0] word_cnt
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!srq && wr_n && !eos && !underrun && word_cnt == '0));

  assert_gate_needs_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(sector_pulse));

  assert_quiet_line_R5: assert property (@(posedge clk) disable iff (rst)
    wr_n |-> !ser_out);

  assert_count_steps_R6: assert property (@(posedge clk) disable iff (rst)
    (word_cnt != $past(word_cnt)) |-> (word_cnt == $past(word_cnt) + 1'b1 || word_cnt == '0));

  assert_no_request_after_eos_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(eos) && eos) |-> !$rose(srq));

  assert_full_count_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (word_cnt == CW'(WORDS)) |-> wr_n);

  assert_sticky_underrun_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(underrun) |-> $past(start));

endmodule

bind sector_write_seq sector_write_seq_chk #(.WORDS(WORDS)) chk (
  .clk(clk), .rst(rst), .start(start), .sector_pulse(sector_pulse),
  .srq(srq), .wr_n(wr_n), .ser_out(ser_out), .eos(eos),
  .underrun(underrun), .word_cnt(word_cnt)
);

// File: tb/sector_write_seq_test.sv
`timescale 1ns/1ps
module sector_write_seq_test;
  localparam int W  = 16;
  localparam int NW = 64;
  localparam int CW = $clog2(NW + 1);

  logic clk = 0, rst = 1, start = 0, sector_pulse = 0, bit_tick = 0;
  logic dma_strobe = 0, dma_clear = 0;
  logic [W-1:0] dma_data = '0;
  logic srq, wr_n, ser_out, eos, underrun;
  logic [CW-1:0] word_cnt;

  int errors = 0, checks = 0;

  sector_write_seq #(.WORD_W(W), .WORDS(NW)) uut (
    .clk(clk), .rst(rst), .start(start), .sector_pulse(sector_pulse),
    .bit_tick(bit_tick), .dma_strobe(dma_strobe), .dma_clear(dma_clear),
    .dma_data(dma_data), .srq(srq), .wr_n(wr_n), .ser_out(ser_out),
    .eos(eos), .underrun(underrun), .word_cnt(word_cnt));

  always #5 clk = ~clk;

  // behavioural reference: mode 0 idle, 1 armed, 2 writing, 3 done
  int m_mode, m_cnt, m_pulses;
  bit m_srq, m_eos, m_und, m_fresh;
  logic [W-1:0] m_stage;
  bit m_bits[$];

  always @(posedge clk) begin
    bit go, move, last;
    go = 0; move = 0; last = 0;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_pulses = 0; m_srq = 0; m_eos = 0;
      m_und = 0; m_fresh = 0; m_stage = '0; m_bits.delete();
    end else begin
      case (m_mode)
        0: if (start) begin go = 1; m_mode = 1; m_cnt = 0; m_und = 0; m_eos = 0; end
        1: if (sector_pulse) begin move = 1; m_mode = 2; end
        2: if (bit_tick) begin
             void'(m_bits.pop_front());
             if (m_bits.size() == 0) begin
               m_cnt++;
               if (m_cnt == NW) m_mode = 3;
               else begin move = 1; last = (m_cnt == NW - 1); end
             end
           end
        default: if (sector_pulse) begin
             m_pulses++;
             if (m_pulses == 2) begin m_mode = 0; m_pulses = 0; m_eos = 0; end
           end
      endcase
      if (move) begin
        if (!m_fresh) m_und = 1;
        m_bits.delete();
        for (int b = W - 1; b >= 0; b--) m_bits.push_back(m_stage[b]);
        if (last) m_eos = 1;
      end
      if (go || (move && !last)) m_srq = 1;
      else if (dma_clear) m_srq = 0;
      if (go || move) m_fresh = 0;
      if (dma_strobe) begin m_stage = dma_data; m_fresh = 1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_ser;
    e_ser = (m_mode == 2 && m_bits.size() > 0) ? m_bits[0] : 1'b0;
    check(srq == m_srq, "R3 srq", srq, m_srq);
    check(wr_n == (m_mode != 2), "R4/R8 wr_n", wr_n, m_mode != 2);
    check(ser_out == e_ser, "R5 ser_out", ser_out, e_ser);
    check(eos == m_eos, "R7 eos", eos, m_eos);
    check(underrun == m_und, "R10 underrun", underrun, m_und);
    check(word_cnt == m_cnt, "R6 word_cnt", word_cnt, m_cnt);
  endtask

  // stimulus control
  int tick_every = 1, latency = 1, skip_req = -1, req_idx = 0, wait_cnt = 0;
  int ph = 0, rises = 0;
  bit prev_srq = 0, answering = 0;
  logic [W-1:0] seed = 16'hA5C3, last_word = '0;
  bit sent_bits[$];
  bit got_bits[$];

  task automatic cyc(input bit st = 0, input bit sp = 0);
    @(negedge clk);
    compare();
    if (srq && !prev_srq) rises++;
    prev_srq = srq;
    start = st; sector_pulse = sp;
    dma_strobe = 0; dma_clear = 0;
    ph++;
    bit_tick = (ph % tick_every == 0);
    if (bit_tick && !wr_n) got_bits.push_back(ser_out);
    if (srq && !answering) begin answering = 1; wait_cnt = latency; end
    if (answering) begin
      if (wait_cnt > 1) wait_cnt--;
      else begin
        answering = 0;
        dma_clear = 1;
        if (req_idx == skip_req) begin
          for (int b = W - 1; b >= 0; b--) sent_bits.push_back(last_word[b]);
        end else begin
          last_word = seed ^ W'(req_idx * 16'h1357);
          dma_data = last_word;
          dma_strobe = 1;
          for (int b = W - 1; b >= 0; b--) sent_bits.push_back(last_word[b]);
        end
        req_idx++;
      end
    end
  endtask

  task automatic stream_check(input string req);
    bit same;
    same = (sent_bits.size() == got_bits.size());
    if (same) foreach (got_bits[i]) if (got_bits[i] != sent_bits[i]) same = 0;
    check(same, req, got_bits.size(), sent_bits.size());
    sent_bits.delete(); got_bits.delete();
  endtask

  task automatic run_sector();
    int guard;
    req_idx = 0; rises = 0;
    cyc(1, 0);
    repeat (6) cyc();
    check(wr_n == 1, "R2 no write before sector", wr_n, 1);
    rises = 1;
    cyc(0, 1);
    guard = 0;
    while (wr_n && guard < 10) begin cyc(); guard++; end
    check(wr_n == 0, "R4 write opens", wr_n, 0);
    guard = 0;
    while (!wr_n && guard < 20000) begin
      if (guard == 37) cyc(1, 1);
      else cyc();
      guard++;
    end
    cyc();
    check(word_cnt == NW, "R8 final count", word_cnt, NW);
    check(eos == 1, "R7 eos at end", eos, 1);
    check(rises == NW, "R7 request count", rises, NW);
  endtask

  initial begin
    repeat (3) cyc();
    check(srq == 0 && wr_n == 1 && eos == 0 && underrun == 0 && word_cnt == 0 && ser_out == 0,
          "R1 reset state", {srq, wr_n, eos, underrun, ser_out}, 5'b01000);
    rst = 0;
    cyc();
    check(wr_n == 1 && srq == 0, "R1 after release", {wr_n, srq}, 2'b10);

    // sector 1: tick every cycle, fast DMA, R11 stimulus mid-run
    run_sector();
    stream_check("R5 serial stream");
    check(underrun == 0, "R10 no underrun", underrun, 0);

    // R9: first pulse is not enough
    cyc(0, 1);
    cyc(1, 0);
    cyc(); cyc();
    check(srq == 0, "R9 start ignored after one pulse", srq, 0);
    cyc(0, 1);
    cyc();
    check(eos == 0, "R9 eos cleared", eos, 0);

    // sector 2: slow ticks, slow DMA, one unanswered request
    tick_every = 3; latency = 3; skip_req = 5; seed = 16'h3C96;
    run_sector();
    stream_check("R10 stale word resent");
    check(underrun == 1, "R10 underrun set", underrun, 1);
    repeat (2) cyc(0, 1);
    cyc(1, 0);
    cyc();
    check(srq == 1 && underrun == 0, "R9 start accepted again", {srq, underrun}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule